// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block sits between a set of peripheral request lines and a CPU core. Ten request inputs, one per vector, are ranked on three urgency levels: L (lowest), H and X (highest). A per-vector configuration bit chooses between the vector's high level and L. The controller picks the most urgent pending request. It posts that request to the core with a registered vector address. It then keeps a small stack of the levels the core is currently serving, so that interrupts can nest.

A request is posted only when the global enable is set and the request's level is strictly above the level now in service. Requests that do not qualify stay pending, because the request lines are level-held. They are taken once a return strobe lowers the service level. The core accepts a posted request with the acknowledge strobe and leaves a handler with the return strobe. Clearing the source flags is left to the peripherals.

Top module: `tlic_top`

## Requirements
- R1: While reset is active and right after it, `irqOut` is 0 and `svcLevel` is 0.
- R2: The vector address for vector n is 3 + 8·n, giving 0x03, 0x0B, …, 0x4B on the 7-bit `vecAddr`.
- R3: The encoding of `svcLevel` is 0 for none, 1 for L, 2 for H and 3 for X. A requesting vector whose `prioSel` bit is 0 has level L. With the bit at 1, vectors 0 and 1 have level X and vectors 2 to 9 have level H.
- R4: Among requesting vectors the one with the highest level wins. Among vectors of equal level, the one with the lowest index (lowest address) wins.
- R5: Suppose no request is posted and, at a clock edge, the global enable is 1 and the winning level is above `svcLevel`. Then `irqOut` is 1 after that edge, with the winner's address. Otherwise the request is held pending and `irqOut` stays 0.
- R6: While a request is posted, `vecAddr` does not change until it is acknowledged, even if a more urgent request arrives. If the global enable is 0 at an edge while a request is posted, `irqOut` is 0 after that edge.
- R7: An acknowledge while `irqOut` is 1 pushes the posted level. After that edge `svcLevel` equals that level and `irqOut` is 0. An acknowledge while `irqOut` is 0 has no effect.
- R8: A return strobe pops the in-service stack, so `svcLevel` goes back to the level that was interrupted. Nesting reaches three levels (L, then H, then X).
- R9: A return strobe is ignored when the in-service stack is empty. It is also ignored in the same cycle as an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 10 | Level-held request, one per vector (bit n = vector n) |
| prioSel | input | 10 | Per-vector level select: 1 = vector's high level, 0 = L |
| globalEn | input | 1 | Global interrupt enable |
| ackStb | input | 1 | Core accepts the posted request (one-cycle strobe) |
| retStb | input | 1 | Core leaves the current handler (one-cycle strobe) |
| irqOut | output | 1 | Interrupt request to the core |
| vecAddr | output | 7 | Address of the posted vector |
| svcLevel | output | 2 | Level currently in service (0 = none) |

## Verification
The bench pushes the stack to full depth (L, H, X) and unwinds it. A stack that dropped an entry would return to level 0 too early and let an L request through during an H handler. It raises equal-level requests together, where a reversed tie-break would post the higher address. It also raises a more urgent request while a vector is posted, where an unregistered vector would change under the core before the acknowledge. Return strobes on an empty stack and alongside an acknowledge are aimed at a depth counter that underflows, or that loses the pushed level, and so reports a wrong service level.

// File: rtl/tlic_pkg.sv
package tlic_pkg;
  localparam int LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_L    = 2'd1;
  localparam lvl_t LVL_H    = 2'd2;
  localparam lvl_t LVL_X    = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // latch winner vector and level
    logic push;   // push latched level on in-service stack
    logic pop;    // pop in-service stack
    logic drop;   // withdraw posted request
  } dpCtl_t;
endpackage

// File: rtl/tlic_control.sv
module tlic_control
  import tlic_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   eligible,
  input  logic   stackEmpty,
  input  logic   globalEn,
  input  logic   ackStb,
  input  logic   retStb,
  output dpCtl_t ctl,
  output logic   posted
);

  always_comb begin
    ctl = '0;
    if (!posted) begin
      ctl.load = eligible;
    end else if (ackStb) begin
      ctl.push = 1'b1;
    end else if (!globalEn) begin
      ctl.drop = 1'b1;
    end
    ctl.pop = retStb && !stackEmpty && !(posted && ackStb);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posted <= 1'b0;
    end else if (ctl.load) begin
      posted <= 1'b1;
    end else if (ctl.push || ctl.drop) begin
      posted <= 1'b0;
    end
  end

  // R6
  drop_on_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    posted && !globalEn && !ackStb |=> !posted);

endmodule

// File: rtl/tlic_datapath.sv
module tlic_datapath
  import tlic_pkg::*;
#(
  parameter int NUM_VEC    = 10,
  parameter int NUM_TOP    = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 7,
  parameter int STK_DEPTH  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] prioSel,
  input  logic               globalEn,
  input  dpCtl_t             ctl,
  input  logic               posted,
  output logic               eligible,
  output logic               stackEmpty,
  output logic [ADDR_W-1:0]  vecAddrQ,
  output lvl_t               topLvl
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int DEP_W = $clog2(STK_DEPTH + 1);

  lvl_t             vecLvl [NUM_VEC];
  lvl_t             winLvl;
  logic [IDX_W-1:0] winIdx;
  lvl_t             pendLvl;
  lvl_t             stk [STK_DEPTH];
  logic [DEP_W-1:0] depth;

  // per-vector effective level; top-level capability chosen per vector
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_lvl
    if (g < NUM_TOP) begin : g_top
      assign vecLvl[g] = !reqIn[g] ? LVL_NONE : (prioSel[g] ? LVL_X : LVL_L);
    end else begin : g_mid
      assign vecLvl[g] = !reqIn[g] ? LVL_NONE : (prioSel[g] ? LVL_H : LVL_L);
    end
  end

  // highest level wins; scanning downward lets the lowest index win ties
  always_comb begin
    winLvl = LVL_NONE;
    winIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (vecLvl[i] != LVL_NONE && vecLvl[i] >= winLvl) begin
        winLvl = vecLvl[i];
        winIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    topLvl = LVL_NONE;
    for (int i = 0; i < STK_DEPTH; i++) begin
      if (depth == DEP_W'(i + 1)) topLvl = stk[i];
    end
  end

  assign stackEmpty = (depth == '0);
  assign eligible   = globalEn && (winLvl > topLvl);

  // posted vector and its level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecAddrQ <= '0;
      pendLvl  <= LVL_NONE;
    end else if (ctl.load) begin
      vecAddrQ <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(winIdx));
      pendLvl  <= winLvl;
    end
  end

  // in-service level stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= LVL_NONE;
    end else if (ctl.push && depth < DEP_W'(STK_DEPTH)) begin
      for (int i = 0; i < STK_DEPTH; i++) begin
        if (depth == DEP_W'(i)) stk[i] <= pendLvl;
      end
      depth <= depth + 1'b1;
    end else if (ctl.pop) begin
      depth <= depth - 1'b1;
    end
  end

  // R5
  pend_above_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    posted |-> pendLvl > topLvl);

  // R6
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    posted && $past(posted) |-> $stable(vecAddrQ));

  // R7
  push_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |=> topLvl == $past(pendLvl));

  // R9
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackEmpty && !ctl.push |=> stackEmpty);

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEP_W'(STK_DEPTH));

endmodule

// File: rtl/tlic_top.sv
module tlic_top
  import tlic_pkg::*;
#(
  parameter int NUM_VEC    = 10,
  parameter int NUM_TOP    = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 7,
  parameter int STK_DEPTH  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] prioSel,
  input  logic               globalEn,
  input  logic               ackStb,
  input  logic               retStb,
  output logic               irqOut,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [1:0]         svcLevel
);

  dpCtl_t ctl;
  logic   eligible;
  logic   stackEmpty;
  logic   posted;
  lvl_t   topLvl;

  tlic_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .eligible   (eligible),
    .stackEmpty (stackEmpty),
    .globalEn   (globalEn),
    .ackStb     (ackStb),
    .retStb     (retStb),
    .ctl        (ctl),
    .posted     (posted)
  );

  tlic_datapath #(
    .NUM_VEC    (NUM_VEC),
    .NUM_TOP    (NUM_TOP),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .ADDR_W     (ADDR_W),
    .STK_DEPTH  (STK_DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqIn      (reqIn),
    .prioSel    (prioSel),
    .globalEn   (globalEn),
    .ctl        (ctl),
    .posted     (posted),
    .eligible   (eligible),
    .stackEmpty (stackEmpty),
    .vecAddrQ   (vecAddr),
    .topLvl     (topLvl)
  );

  assign irqOut   = posted;
  assign svcLevel = topLvl;

  // R7
  ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && ackStb |=> !irqOut && svcLevel != 2'd0);

endmodule

// File: tb/tlic_top_tb_top.sv
module tlic_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] req, prio;
  logic       gEn, ack, ret;
  logic       irq;
  logic [6:0] vaddr;
  logic [1:0] svc;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // reference state
  bit mPosted;
  int mVec, mLvl, mDepth;
  int mStk [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlic_top dut_i (
    .clk(clk), .rstN(rstN), .reqIn(req), .prioSel(prio), .globalEn(gEn),
    .ackStb(ack), .retStb(ret), .irqOut(irq), .vecAddr(vaddr), .svcLevel(svc)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // level of vector n per R3
  function automatic int lvlOf(input int n, input logic [9:0] r, input logic [9:0] p);
    if (!r[n]) return 0;
    if (!p[n]) return 1;
    return (n < 2) ? 3 : 2;
  endfunction

  // winner per R4: returns level, index through argument
  function automatic int winner(input logic [9:0] r, input logic [9:0] p, output int idx);
    int best = 0;
    idx = 0;
    for (int n = 0; n < 10; n++) begin
      if (lvlOf(n, r, p) > best) begin
        best = lvlOf(n, r, p);
        idx = n;
      end
    end
    return best;
  endfunction

  task automatic modelEdge();
    int wi, wl, top;
    bit doPop;
    wl = winner(req, prio, wi);
    top = (mDepth > 0) ? mStk[mDepth-1] : 0;
    doPop = ret && (mDepth > 0) && !(mPosted && ack);
    if (!mPosted) begin
      if (gEn && wl > top) begin
        mPosted = 1; mVec = 3 + 8 * wi; mLvl = wl;
      end
    end else if (ack) begin
      mStk[mDepth] = mLvl; mDepth++; mPosted = 0;
    end else if (!gEn) begin
      mPosted = 0;
    end
    if (doPop) mDepth--;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    #1;
    check({tag, " irq"}, int'(irq), int'(mPosted));
    check({tag, " svc"}, int'(svc), (mDepth > 0) ? mStk[mDepth-1] : 0);
    if (mPosted) check({tag, " addr"}, int'(vaddr), mVec);
  endtask

  task automatic pulseAck(input string tag);
    ack = 1; step(tag); ack = 0;
  endtask

  task automatic pulseRet(input string tag);
    ret = 1; step(tag); ret = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 0; req = '0; prio = '0; gEn = 0; ack = 0; ret = 0;
    mPosted = 0; mVec = 0; mLvl = 0; mDepth = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", int'(irq), 0);
    check("R1 svc in reset", int'(svc), 0);
    rstN = 1;
    step("R1 after reset");

    // R5: pending while disabled, posted once enabled
    req[4] = 1;
    step("R5 disabled");
    check("R5 held pending", int'(irq), 0);
    gEn = 1;
    step("R5 enabled");
    check("R2 addr vec4", int'(vaddr), 8'h23);

    // R6: more urgent arrival does not move posted vector
    req[1] = 1; prio[1] = 1;
    step("R6 hold");
    check("R6 addr stable", int'(vaddr), 8'h23);

    pulseAck("R7 ack L");
    check("R7 svc L", int'(svc), 1);
    check("R7 irq low", int'(irq), 0);
    step("R3 X posts over L");
    check("R3 X addr", int'(vaddr), 8'h0B);
    pulseAck("R7 ack X");
    check("R3 svc X", int'(svc), 3);
    req[1] = 0;
    step("R5 L under X");
    pulseRet("R8 pop X");
    check("R8 back to L", int'(svc), 1);
    step("R5 L not above L");
    check("R5 equal level pending", int'(irq), 0);
    pulseRet("R8 pop L");
    step("R5 L posts at level 0");
    check("R5 L reposted", int'(irq), 1);
    ack = 1; ret = 1; step("R9 ret with ack"); ack = 0; ret = 0;
    check("R9 ret ignored with ack", int'(svc), 1);
    pulseRet("R8 pop");
    req = '0;
    step("idle");
    pulseRet("R9 empty ret");
    check("R9 empty stays 0", int'(svc), 0);
    pulseAck("R7 ack ignored");
    check("R7 stray ack", int'(svc), 0);

    // R4 ties and R3 levels
    req = 10'b0010001000; prio = 10'b0010001000;
    step("R4 tie");
    check("R4 lowest addr", int'(vaddr), 8'h1B);
    gEn = 0; step("R6 drop"); check("R6 dropped", int'(irq), 0);
    req = 10'b1000000001; prio = 10'b1000000000; gEn = 1;
    step("R3 H over L");
    check("R3 vec9 H", int'(vaddr), 8'h4B);
    pulseAck("R7 ack H");
    check("R3 svc H", int'(svc), 2);
    pulseRet("R8 pop H");
    req = '0; prio = '0; step("idle");

    // R8 three-deep nesting
    req[9] = 1; step("R8 L"); pulseAck("R8 ack L");
    req[5] = 1; prio[5] = 1; step("R8 H"); pulseAck("R8 ack H");
    req[0] = 1; prio[0] = 1; step("R8 X"); pulseAck("R8 ack X");
    check("R8 depth3 svc", int'(svc), 3);
    req = '0;
    pulseRet("R8 ret1"); check("R8 unwind H", int'(svc), 2);
    pulseRet("R8 ret2"); check("R8 unwind L", int'(svc), 1);
    pulseRet("R8 ret3"); check("R8 unwind none", int'(svc), 0);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 4 == 0) req = req ^ (10'(1) << ($urandom % 10));
      if ($urandom % 16 == 0) prio = 10'($urandom);
      gEn = ($urandom % 10) != 0;
      ack = irq ? ($urandom % 2 == 0) : ($urandom % 20 == 0);
      ret = ($urandom % 8) == 0;
      step("R4 R5 random");
    end
    ack = 0; ret = 0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule